// File: doc/BRIEF.md
# Serial ADC readout controller

This block is the host side of a three-wire link to a 12-bit sampling analog-to-digital converter. A single-cycle start request pulls chip select low. The block then produces a serial data clock derived from the system clock and counts its rising edges. It skips the converter's sampling and null-bit periods and shifts in the 12-bit straight-binary result, most significant bit first. At the end of the frame it releases chip select and presents the result together with a one-cycle valid strobe.

An optional integrity mode is chosen per frame by the level of `verify_i` when the start is accepted. In that mode the block keeps clocking while the converter repeats the word least significant bit first. It compares those eleven repeated bits with bits 1 to 11 of the captured word and raises a mismatch flag on any difference. The data clock rate is fixed at elaboration from two parameters, the system clock frequency and the highest serial clock frequency allowed. The half period is rounded up, so the limit is never exceeded.

Top module: `sar_readout_ctrl`

## Requirements
- R1: After reset, `csn_o` is 1, `sclk_o` is 0, `busy_o` is 0, `valid_o` is 0, `result_o` is 0 and `mismatch_o` is 0.
- R2: A `start_i` high while `busy_o` is 0 is accepted. On the next clock edge `csn_o` falls and `busy_o` rises, and `busy_o` stays the inverse of `csn_o` until chip select returns high.
- R3: A `start_i` pulse while `busy_o` is 1 is ignored. The running frame is neither restarted nor extended, and each accepted start yields exactly one `valid_o` pulse.
- R4: Each high and each low phase of `sclk_o` lasts HALF system clocks, where HALF = ceil(CLK_HZ / (2*SCLK_MAX_HZ)) and is at least 1. `sclk_o` is low whenever `csn_o` is high, and at least HALF clocks pass between `csn_o` falling and the first rising edge of `sclk_o`.
- R5: `sdata_i` is sampled only at rising edges of `sclk_o`. Rising edges 1 and 2 (the sampling period) and 3 (the null bit) are discarded whatever level they carry.
- R6: Rising edges 4 to 15 carry result bits 11 down to 0. `result_o` is the straight-binary code 0 to 4095 built from them.
- R7: With `verify_i` low at the accepted start, a frame has exactly 15 rising edges of `sclk_o`, and `mismatch_o` is 0.
- R8: With `verify_i` high at the accepted start, a frame has exactly 26 rising edges, where edge 15+k carries a repeat of result bit k for k = 1..11. `mismatch_o` is 1 exactly when any repeated bit differs from the captured bit.
- R9: After the last rising edge, `sclk_o` falls after HALF clocks. After HALF more clocks `csn_o` rises, and in that same cycle `valid_o` pulses for one cycle. `result_o` and `mismatch_o` change only on that cycle and hold until the next one.
- R10: Changes of `verify_i` while a frame runs do not affect that frame's edge count or its mismatch result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion readout |
| verify_i | input | 1 | Integrity mode select, sampled when a start is accepted |
| sdata_i | input | 1 | Serial data from the converter |
| csn_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial data clock, idles low |
| busy_o | output | 1 | Frame in progress |
| valid_o | output | 1 | One-cycle strobe: new result available |
| result_o | output | 12 | Captured conversion code |
| mismatch_o | output | 1 | Repeated bits disagreed with the captured word |

## Verification
The converter model drives all-zero, all-one, single-bit-at-either-end and alternating codes. These separate a bit-order reversal, an off-by-one in the capture window and a stuck shift position. The pre-data edges are held high and the null bit is driven both ways, so a capture window that starts too early corrupts the upper bits. In integrity mode the model flips one repeated bit at the low end, the high end and the middle of the repeat to prove the comparison maps each position. It also runs clean repeats, and it runs normal-mode frames where a flip must stay invisible. Further frames send start pulses and toggle the mode input mid-frame to show that neither alters the running frame.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

    localparam int WORD_W_DFLT = 12;
    localparam int LEAD_EDGES_DFLT = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_CLOCK = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_e;

    // Per-cycle events passed from the sequencer to the capture datapath.
    typedef struct packed {
        logic launch;  // start accepted this cycle
        logic rise;    // sclk goes high at this edge: sample now
        logic finish;  // chip select released at this edge
    } seq_evt_t;

    // Half period in system clocks, rounded up so the serial clock never
    // exceeds the requested maximum.
    function automatic int calc_half(input longint clk_hz, input longint sclk_hz);
        longint h;
        h = (clk_hz + 2 * sclk_hz - 1) / (2 * sclk_hz);
        if (h < 1) h = 1;
        return int'(h);
    endfunction

endpackage

// File: rtl/sar_rd_div.sv
module sar_rd_div #(
    parameter int HALF = 4,
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic tick_o
);
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sar_rd_seq.sv
module sar_rd_seq
    import sar_rd_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int LEAD_EDGES = 3,
    localparam int EW = $clog2(LEAD_EDGES + 2 * DATA_W) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          verify_i,
    input  logic          tick_i,
    output logic          run_o,
    output logic          csn_o,
    output logic          sclk_o,
    output logic          busy_o,
    output logic          verify_q_o,
    output seq_evt_t      evt_o,
    output logic [EW-1:0] edge_idx_o
);
    localparam logic [EW-1:0] LAST_PLAIN  = EW'(LEAD_EDGES + DATA_W);
    localparam logic [EW-1:0] LAST_VERIFY = EW'(LEAD_EDGES + 2 * DATA_W - 1);

    seq_state_e    state_q;
    logic [EW-1:0] ecnt_q;
    logic [EW-1:0] last_edge;

    assign last_edge  = verify_q_o ? LAST_VERIFY : LAST_PLAIN;
    assign run_o      = (state_q != ST_IDLE);
    assign edge_idx_o = ecnt_q + 1'b1;

    always_comb begin
        evt_o.launch = (state_q == ST_IDLE) && start_i;
        evt_o.rise   = (state_q == ST_CLOCK) && tick_i && !sclk_o;
        evt_o.finish = (state_q == ST_HOLD) && tick_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            csn_o      <= 1'b1;
            sclk_o     <= 1'b0;
            busy_o     <= 1'b0;
            verify_q_o <= 1'b0;
            ecnt_q     <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q    <= ST_SETUP;
                        csn_o      <= 1'b0;
                        busy_o     <= 1'b1;
                        verify_q_o <= verify_i;
                        ecnt_q     <= '0;
                    end
                end
                ST_SETUP: begin
                    if (tick_i) state_q <= ST_CLOCK;
                end
                ST_CLOCK: begin
                    if (tick_i) begin
                        if (!sclk_o) begin
                            sclk_o <= 1'b1;
                            ecnt_q <= ecnt_q + 1'b1;
                        end else begin
                            sclk_o <= 1'b0;
                            if (ecnt_q == last_edge) state_q <= ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick_i) begin
                        state_q <= ST_IDLE;
                        csn_o   <= 1'b1;
                        busy_o  <= 1'b0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_rd_capture.sv
module sar_rd_capture
    import sar_rd_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int LEAD_EDGES = 3,
    localparam int EW = $clog2(LEAD_EDGES + 2 * DATA_W) + 1,
    localparam int PW = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_evt_t          evt_i,
    input  logic [EW-1:0]     edge_idx_i,
    input  logic              verify_i,
    input  logic              sdata_i,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              mismatch_o
);
    localparam logic [EW-1:0] WORD_FIRST = EW'(LEAD_EDGES + 1);
    localparam logic [EW-1:0] WORD_LAST  = EW'(LEAD_EDGES + DATA_W);
    localparam logic [EW-1:0] MIR_FIRST  = EW'(LEAD_EDGES + DATA_W + 1);
    localparam logic [EW-1:0] MIR_LAST   = EW'(LEAD_EDGES + 2 * DATA_W - 1);

    logic [DATA_W-1:0] word_q;
    logic              mis_q;
    logic              in_word;
    logic              in_mirror;
    logic [EW-1:0]     mir_off;
    logic [PW-1:0]     mir_pos;
    logic              ref_bit;

    always_comb begin
        in_word   = (edge_idx_i >= WORD_FIRST) && (edge_idx_i <= WORD_LAST);
        in_mirror = verify_i && (edge_idx_i >= MIR_FIRST) && (edge_idx_i <= MIR_LAST);
        mir_off   = edge_idx_i - WORD_LAST;
        mir_pos   = mir_off[PW-1:0];
        ref_bit   = word_q[mir_pos];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q     <= '0;
            mis_q      <= 1'b0;
            result_o   <= '0;
            valid_o    <= 1'b0;
            mismatch_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (evt_i.launch) begin
                word_q <= '0;
                mis_q  <= 1'b0;
            end else if (evt_i.rise) begin
                if (in_word) word_q <= {word_q[DATA_W-2:0], sdata_i};
                if (in_mirror && (sdata_i != ref_bit)) mis_q <= 1'b1;
            end
            if (evt_i.finish) begin
                result_o   <= word_q;
                mismatch_o <= mis_q;
                valid_o    <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl
    import sar_rd_pkg::*;
#(
    parameter longint CLK_HZ      = 200_000_000,
    parameter longint SCLK_MAX_HZ = 200_000,
    parameter int     DATA_W      = WORD_W_DFLT,
    parameter int     LEAD_EDGES  = LEAD_EDGES_DFLT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              verify_i,
    input  logic              sdata_i,
    output logic              csn_o,
    output logic              sclk_o,
    output logic              busy_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic              mismatch_o
);
    localparam int HALF = calc_half(CLK_HZ, SCLK_MAX_HZ);
    localparam int EW   = $clog2(LEAD_EDGES + 2 * DATA_W) + 1;

    logic          run;
    logic          tick;
    logic          verify_q;
    seq_evt_t      evt;
    logic [EW-1:0] edge_idx;

    sar_rd_div #(.HALF(HALF)) u_div (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .tick_o (tick)
    );

    sar_rd_seq #(.DATA_W(DATA_W), .LEAD_EDGES(LEAD_EDGES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .verify_i   (verify_i),
        .tick_i     (tick),
        .run_o      (run),
        .csn_o      (csn_o),
        .sclk_o     (sclk_o),
        .busy_o     (busy_o),
        .verify_q_o (verify_q),
        .evt_o      (evt),
        .edge_idx_o (edge_idx)
    );

    sar_rd_capture #(.DATA_W(DATA_W), .LEAD_EDGES(LEAD_EDGES)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .edge_idx_i (edge_idx),
        .verify_i   (verify_q),
        .sdata_i    (sdata_i),
        .result_o   (result_o),
        .valid_o    (valid_o),
        .mismatch_o (mismatch_o)
    );
endmodule

// File: rtl/sar_readout_chk.sv
module sar_readout_chk #(
    parameter int HALF = 4,
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              csn_o,
    input logic              sclk_o,
    input logic              busy_o,
    input logic              valid_o,
    input logic [DATA_W-1:0] result_o,
    input logic              mismatch_o
);
    logic sclk_d;
    int   gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            gap    <= HALF;
        end else begin
            sclk_d <= sclk_o;
            if (sclk_o != sclk_d) gap <= 1;
            else if (gap < HALF) gap <= gap + 1;
        end
    end

    AST_BUSY_TRACKS_CS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (busy_o != csn_o)); // R2

    AST_LAUNCH_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(csn_o) |-> ($past(start_i) && !$past(busy_o))); // R3

    AST_CLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        csn_o |-> !sclk_o); // R4

    AST_SETUP_BEFORE_EDGE: assert property (@(posedge clk) disable iff (rst)
        $fell(csn_o) |=> !sclk_o); // R4

    AST_HALF_PERIOD_MIN: assert property (@(posedge clk) disable iff (rst)
        (sclk_o != sclk_d) |-> (gap >= HALF)); // R4

    AST_VALID_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $rose(csn_o)); // R9

    AST_VALID_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o); // R9

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ($stable(result_o) && $stable(mismatch_o))); // R9
endmodule

bind sar_readout_ctrl sar_readout_chk #(.HALF(HALF), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .csn_o      (csn_o),
    .sclk_o     (sclk_o),
    .busy_o     (busy_o),
    .valid_o    (valid_o),
    .result_o   (result_o),
    .mismatch_o (mismatch_o)
);

// File: tb/tb_sar_readout_ctrl.sv
`timescale 1ns/1ps
module tb_sar_readout_ctrl;
    localparam int  W     = 12;
    localparam int  HALF  = 4;     // 200 MHz / (2 * 25 MHz)
    localparam real TCLK  = 5.0;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         verify_i = 1'b0;
    logic         sdata_i = 1'b1;
    logic         csn_o, sclk_o, busy_o, valid_o, mismatch_o;
    logic [W-1:0] result_o;

    always #(TCLK / 2) clk = ~clk;

    sar_readout_ctrl #(
        .CLK_HZ(200_000_000), .SCLK_MAX_HZ(25_000_000), .DATA_W(W), .LEAD_EDGES(3)
    ) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .verify_i(verify_i), .sdata_i(sdata_i),
        .csn_o(csn_o), .sclk_o(sclk_o), .busy_o(busy_o), .valid_o(valid_o),
        .result_o(result_o), .mismatch_o(mismatch_o)
    );

    typedef struct {
        logic [W-1:0] code;
        logic         mis;
        int           edges;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   n_valid = 0;

    // converter model controls
    logic [W-1:0] adc_word = '0;
    logic         adc_null = 1'b0;
    int           adc_flip = 0;   // repeat bit position to invert, 0 = none
    int           nfall = 0;
    int           rise_cnt = 0;
    realtime      t_rise = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic adc_bit(input int n);
        logic b;
        if (n <= 2) return 1'b1;               // not yet driven: pulled high
        if (n == 3) return adc_null;
        if (n <= 15) return adc_word[15 - n];
        if (n <= 26) begin
            b = adc_word[n - 15];
            if ((n - 15) == adc_flip) b = ~b;
            return b;
        end
        return 1'b0;
    endfunction

    // converter model: new bit after each falling edge, reset on deselect
    always @(negedge sclk_o or posedge csn_o) begin
        if (csn_o) begin
            nfall = 0;
            #1 sdata_i = 1'b1;
        end else begin
            nfall = nfall + 1;
            #1 sdata_i = adc_bit(nfall + 1);
        end
    end

    always @(posedge sclk_o or negedge csn_o) begin
        if (sclk_o) begin
            rise_cnt = rise_cnt + 1;
            t_rise = $realtime;
        end else begin
            rise_cnt = 0;
        end
    end

    // R4: high phase width
    always @(negedge sclk_o) begin
        if (!rst) check(($realtime - t_rise) == HALF * TCLK, "R4", "sclk high ns",
                        longint'($realtime - t_rise), longint'(HALF * TCLK));
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        exp_t e;
        if (!rst && valid_o) begin
            n_valid++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R3", "unexpected valid", 1, 0);
            end else begin
                e = exp_q.pop_front();
                check(result_o == e.code, "R6", "result", result_o, e.code);
                check(mismatch_o == e.mis, "R8", "mismatch", mismatch_o, e.mis);
                check(rise_cnt == e.edges, "R7", "rising edges", rise_cnt, e.edges);
                check(csn_o && !busy_o, "R9", "cs released with valid", csn_o, 1);
            end
        end
    end

    task automatic run_frame(input logic [W-1:0] word, input logic verify,
                             input logic nullv, input int flip,
                             input bit poke_start, input bit toggle_verify);
        exp_t e;
        int   setup;
        adc_word = word;
        adc_null = nullv;
        adc_flip = flip;
        e.code  = word;
        e.edges = verify ? 26 : 15;
        e.mis   = verify && (flip >= 1) && (flip <= 11);
        exp_q.push_back(e);
        @(negedge clk);
        start_i  = 1'b1;
        verify_i = verify;
        @(negedge clk);
        start_i = 1'b0;
        check(!csn_o && busy_o, "R2", "cs low and busy after start", {csn_o, busy_o}, 2'b01);
        setup = 1;
        while (!sclk_o) begin
            @(negedge clk);
            setup++;
        end
        check(setup > HALF, "R4", "setup clocks", setup, HALF + 1);
        if (toggle_verify) verify_i = ~verify_i;  // R10
        repeat (20) @(negedge clk);
        if (poke_start) begin                      // R3
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (busy_o) begin
            check(busy_o == !csn_o, "R2", "busy inverse of cs", busy_o, !csn_o);
            @(negedge clk);
        end
        repeat (30) @(negedge clk);
        check(csn_o && !busy_o && !sclk_o, "R3", "idle after frame",
              {csn_o, busy_o, sclk_o}, 3'b100);
        check(exp_q.size() == 0, "R3", "pending results", exp_q.size(), 0);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] held;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(csn_o && !sclk_o && !busy_o && !valid_o && result_o == 0 && !mismatch_o,
              "R1", "reset state", {csn_o, sclk_o, busy_o, valid_o, mismatch_o}, 5'b10000);

        // R5 R6 R7: plain frames, pre-data edges high, null bit both levels
        run_frame(12'h000, 1'b0, 1'b1, 0, 0, 0);
        run_frame(12'hFFF, 1'b0, 1'b0, 0, 0, 0);
        run_frame(12'h001, 1'b0, 1'b1, 0, 0, 0);
        run_frame(12'h800, 1'b0, 1'b1, 0, 0, 0);
        run_frame(12'hA5C, 1'b0, 1'b0, 0, 0, 0);
        // R7: corrupt repeat never clocked in plain mode
        run_frame(12'h3C5, 1'b0, 1'b1, 4, 0, 0);

        // R8: integrity mode clean and with a flipped repeat bit
        run_frame(12'h5A3, 1'b1, 1'b0, 0, 0, 0);
        run_frame(12'hFFF, 1'b1, 1'b1, 0, 0, 0);
        run_frame(12'h5A3, 1'b1, 1'b0, 1, 0, 0);
        run_frame(12'h000, 1'b1, 1'b0, 11, 0, 0);
        run_frame(12'h6B9, 1'b1, 1'b1, 6, 0, 0);

        // R3 R10: start poked mid-frame, mode toggled mid-frame
        run_frame(12'h123, 1'b0, 1'b0, 2, 1, 1);
        run_frame(12'hABC, 1'b1, 1'b0, 0, 1, 1);

        // R9: result holds between frames
        held = result_o;
        repeat (50) @(negedge clk);
        check(result_o == held && !valid_o, "R9", "result held", result_o, held);
        check(n_valid == 13, "R3", "valid pulse count", n_valid, 13);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule